// File: doc/BRIEF.md
# Start-Edge Triggered Serial Character Receiver

This block takes in one character at a time from a slow serial line whose bit interval is fixed. The character begins with a high start bit. The rising edge of that start bit, after the line passes through a synchronizer, opens a receive window. At the start of the window a short preset forces every stage of the shift register to one. A bit clock is then gated through a shorter start window. Its first strobe falls half a bit interval after the start edge, and each later strobe follows one full bit interval after the one before. Each strobe shifts the current line level into the register.

After the eighth strobe, the start bit sits in the top stage. The block then copies the seven bits that followed the start bit to a registered parallel output. It also raises a one-cycle valid pulse and a parity verdict on the same cycle. Rising edges on the line are ignored while the receive window is open. Reception runs only while receive-mode enable is high. All timing is given as parameters in system clock cycles.

Top module: `edge_start_rx`

## Requirements
- R1: A rising edge of `rx_line`, seen while `rx_busy` is low and `rx_en` is high, starts a reception. If the line first reads high just before clock edge E0, `rx_busy` reads high after edge E2 and stays low after E1.
- R2: `rx_busy` stays high for exactly `RX_WIN` cycles. It reads low again after edge E(`RX_WIN`+2).
- R3: The line is sampled 8 times. Sample k (k = 0..7) takes the line level present at edge E(`HALF_BIT`+1+k*`BIT_CYC`). Sample 0 is the start bit.
- R4: `rx_data` bit 6 holds sample 1, the first bit after the start bit. `rx_data` bit 0 holds sample 7, the last bit.
- R5: `rx_valid` is high for exactly one cycle per completed character, after edge E(4+`HALF_BIT`+7*`BIT_CYC`). `rx_data` and `rx_perr` are valid in that same cycle.
- R6: With odd sense (`PAR_SENSE` = PAR_ODD, the default), `rx_perr` is 1 exactly when `rx_data` holds an even number of ones. With even sense, it is 1 exactly when the count is odd.
- R7: A rising edge on the line while `rx_busy` is high neither restarts nor extends the window. A line that is still high when the window closes starts nothing.
- R8: While `rx_en` is low, no reception starts. If `rx_en` falls before the eighth sample, no `rx_valid` is produced, but the window still runs its full length.
- R9: After reset, `rx_data`, `rx_valid`, `rx_perr` and `rx_busy` are all 0. `rx_data` and `rx_perr` hold their values between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input line |
| rx_en | input | 1 | Receive-mode enable |
| rx_data | output | 7 | Received code; the first bit after the start bit is the MSB |
| rx_valid | output | 1 | One-cycle pulse on parallel transfer |
| rx_perr | output | 1 | Parity fault for the current `rx_data` |
| rx_busy | output | 1 | Receive window open |

## Verification
Each result is due a fixed number of clock edges after the first edge that sees the start level. `rx_busy` is due 2 edges after it. The window closes `RX_WIN`+2 edges after it. The data, valid and parity outputs are due 4+`HALF_BIT`+7*`BIT_CYC` edges after it: two synchronizer flops, the start flop, the eighth shift and the output register. The bench counts edges from that point in a single loop. It drives each bit on the falling clock edge and samples 1 ns after each rising edge. It records the exact cycle in which `rx_busy` rises and falls and in which `rx_valid` pulses, then compares those indices with the formulas above. A start that is late or early by one cycle, or a valid pulse that is doubled or missing, is therefore reported rather than absorbed.

// File: rtl/edge_start_rx_pkg.sv
package edge_start_rx_pkg;

  // Which count of ones in the received code counts as correct.
  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_sense_e;

  // Default timing, in system clock cycles (scaled-down bit interval).
  localparam int DEF_BIT_CYC   = 16;
  localparam int DEF_HALF_BIT  = 8;
  localparam int DEF_START_WIN = 124;
  localparam int DEF_RX_WIN    = 145;
  localparam int DEF_PULSE_W   = 2;
  localparam int DEF_PRESET    = 2;
  localparam int DEF_SAMPLES   = 8;

endpackage

// File: rtl/edge_start_rx_sync.sv
module edge_start_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= line_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= 1'b0;
      else     chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign line_s = chain[STAGES-1];
  assign rise   = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/edge_start_rx_timer.sv
module edge_start_rx_timer #(
  parameter int BIT_CYC   = 16,
  parameter int HALF_BIT  = 8,
  parameter int START_WIN = 124,
  parameter int RX_WIN    = 145,
  parameter int PULSE_W   = 2,
  parameter int PRESET    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic rx_en,
  output logic active,
  output logic preset,
  output logic shift_go
);

  localparam int CW = $clog2(RX_WIN + 1);
  localparam int PW = $clog2(BIT_CYC + 1);
  localparam int RW = $clog2(PRESET + 1);
  localparam logic [CW-1:0] WIN_LAST  = CW'(RX_WIN - 1);
  localparam logic [CW-1:0] START_LIM = CW'(START_WIN);
  localparam logic [PW-1:0] PH_LOAD   = PW'(BIT_CYC - HALF_BIT);
  localparam logic [PW-1:0] PH_LAST   = PW'(BIT_CYC - 1);
  localparam logic [PW-1:0] PH_HIGH   = PW'(PULSE_W);
  localparam logic [RW-1:0] PRE_LOAD  = RW'(PRESET);

  logic [CW-1:0] cnt;
  logic [PW-1:0] ph;
  logic [RW-1:0] pre_cnt;
  logic          bclk, bclk_d, start_win;

  // Bit clock: phase is loaded so that it wraps to zero HALF_BIT cycles
  // after the start, then every BIT_CYC cycles.
  assign bclk      = active && (ph < PH_HIGH);
  assign start_win = active && (cnt < START_LIM);
  assign preset    = active && (pre_cnt != '0);
  assign shift_go  = rx_en && start_win && bclk && !bclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      ph      <= '0;
      pre_cnt <= '0;
      bclk_d  <= 1'b0;
    end else begin
      bclk_d <= bclk;
      if (!active) begin
        if (rise && rx_en) begin
          active  <= 1'b1;
          cnt     <= '0;
          ph      <= PH_LOAD;
          pre_cnt <= PRE_LOAD;
        end
      end else begin
        cnt <= cnt + 1'b1;
        ph  <= (ph == PH_LAST) ? '0 : ph + 1'b1;
        if (pre_cnt != '0) pre_cnt <= pre_cnt - 1'b1;
        if (cnt == WIN_LAST) active <= 1'b0;
      end
    end
  end

  // R3: strobes only once the half-bit offset has passed
  p_shift_after_offset_r3: assert property (@(posedge clk) disable iff (rst)
    shift_go |-> (active && cnt >= CW'(HALF_BIT)));

  // R7: an edge inside the window never reloads the count
  p_no_restart_r7: assert property (@(posedge clk) disable iff (rst)
    (active && rise) |=> (cnt != '0));

endmodule

// File: rtl/edge_start_rx_shreg.sv
module edge_start_rx_shreg #(
  parameter int SAMPLES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               preset,
  input  logic               shift_go,
  input  logic               din,
  output logic [SAMPLES-1:0] sreg,
  output logic               full
);

  localparam int SW = $clog2(SAMPLES + 1);
  localparam logic [SW-1:0] S_LAST = SW'(SAMPLES - 1);
  localparam logic [SW-1:0] S_ALL  = SW'(SAMPLES);

  logic [SW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      scnt <= '0;
      full <= 1'b0;
    end else if (preset) begin
      sreg <= '1;
      scnt <= '0;
      full <= 1'b0;
    end else begin
      full <= 1'b0;
      if (shift_go && scnt != S_ALL) begin
        sreg <= {sreg[SAMPLES-2:0], din};
        scnt <= scnt + 1'b1;
        full <= (scnt == S_LAST);
      end
    end
  end

  // R3: never more than SAMPLES shifts per character
  p_shift_bound_r3: assert property (@(posedge clk) disable iff (rst)
    scnt <= S_ALL);

  // R5: the full flag is a single-cycle event
  p_full_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    full |=> !full);

endmodule

// File: rtl/edge_start_rx_check.sv
module edge_start_rx_check
  import edge_start_rx_pkg::*;
#(
  parameter int         CODE_W    = 7,
  parameter par_sense_e PAR_SENSE = PAR_ODD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              full,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] data_q,
  output logic              valid_q,
  output logic              perr_q
);

  logic fault;

  if (PAR_SENSE == PAR_ODD) begin : g_odd
    assign fault = ~(^code);
  end else begin : g_even
    assign fault = ^code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
    end else begin
      valid_q <= full;
      if (full) begin
        data_q <= code;
        perr_q <= fault;
      end
    end
  end

  // R5: valid is one cycle wide
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R9: outputs hold between transfers
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(full) |-> ($stable(data_q) && $stable(perr_q)));

endmodule

// File: rtl/edge_start_rx.sv
module edge_start_rx
  import edge_start_rx_pkg::*;
#(
  parameter int         BIT_CYC     = DEF_BIT_CYC,
  parameter int         HALF_BIT    = DEF_HALF_BIT,
  parameter int         START_WIN   = DEF_START_WIN,
  parameter int         RX_WIN      = DEF_RX_WIN,
  parameter int         PULSE_W     = DEF_PULSE_W,
  parameter int         PRESET      = DEF_PRESET,
  parameter int         SAMPLES     = DEF_SAMPLES,
  parameter int         SYNC_STAGES = 2,
  parameter par_sense_e PAR_SENSE   = PAR_ODD,
  localparam int        CODE_W      = SAMPLES - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              rx_en,
  output logic [CODE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_perr,
  output logic              rx_busy
);

  logic               line_s, rise_w, preset_w, shift_w, full_w;
  logic [SAMPLES-1:0] sreg_w;

  edge_start_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_in (rx_line),
    .line_s  (line_s),
    .rise    (rise_w)
  );

  edge_start_rx_timer #(
    .BIT_CYC   (BIT_CYC),
    .HALF_BIT  (HALF_BIT),
    .START_WIN (START_WIN),
    .RX_WIN    (RX_WIN),
    .PULSE_W   (PULSE_W),
    .PRESET    (PRESET)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .rise     (rise_w),
    .rx_en    (rx_en),
    .active   (rx_busy),
    .preset   (preset_w),
    .shift_go (shift_w)
  );

  edge_start_rx_shreg #(.SAMPLES(SAMPLES)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .preset   (preset_w),
    .shift_go (shift_w),
    .din      (line_s),
    .sreg     (sreg_w),
    .full     (full_w)
  );

  edge_start_rx_check #(
    .CODE_W    (CODE_W),
    .PAR_SENSE (PAR_SENSE)
  ) u_check (
    .clk     (clk),
    .rst     (rst),
    .full    (full_w),
    .code    (sreg_w[CODE_W-1:0]),
    .data_q  (rx_data),
    .valid_q (rx_valid),
    .perr_q  (rx_perr)
  );

  // R1: the window opens only after an accepted start edge
  p_busy_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_busy) |-> $past(rise_w && rx_en));

  // R5: transfers land inside the receive window
  p_valid_in_window_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_busy);

endmodule

// File: tb/sim_edge_start_rx.sv
`timescale 1ns/1ps
module sim_edge_start_rx;

  localparam int BIT    = 16;
  localparam int HALF   = 8;
  localparam int WIN    = 145;
  localparam int T_BUSY = 2;
  localparam int T_FALL = WIN + 2;
  localparam int T_VAL  = 4 + HALF + 7 * BIT;

  // {expected parity fault (odd sense), 7-bit code}
  localparam logic [7:0] VEC [7] = '{
    {1'b1, 7'h00}, {1'b0, 7'h7F}, {1'b1, 7'h55}, {1'b0, 7'h2A},
    {1'b0, 7'h01}, {1'b0, 7'h40}, {1'b1, 7'h33}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b0;
  logic       rx_en = 1'b1;
  logic [6:0] rx_data;
  logic       rx_valid, rx_perr, rx_busy;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  edge_start_rx u0 (
    .clk      (clk),
    .rst      (rst),
    .rx_line  (rx_line),
    .rx_en    (rx_en),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_perr  (rx_perr),
    .rx_busy  (rx_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one frame (start bit + 7 code bits) counted from edge E0 and
  // records the cycle indices of the observable events.
  int         v_cyc, n_val, b_rise, b_fall, n_rise;
  logic [6:0] v_data;
  logic       v_perr;

  task automatic frame(input logic [6:0] code, input bit send, input int en_off,
                       input int hold_lo, input int hold_hi, input int ncyc);
    logic prev_busy = rx_busy;
    v_cyc = -1; n_val = 0; b_rise = -1; b_fall = -1; n_rise = 0;
    v_data = '0; v_perr = 1'b0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (send && i < 8 * BIT)
        rx_line = (i < BIT) ? 1'b1 : code[7 - i / BIT];
      else
        rx_line = (i >= hold_lo && i < hold_hi);
      rx_en = !(en_off >= 0 && i >= en_off);
      @(posedge clk);
      #1;
      if (rx_valid) begin
        if (v_cyc < 0) begin v_cyc = i; v_data = rx_data; v_perr = rx_perr; end
        n_val++;
      end
      if (rx_busy && !prev_busy) begin n_rise++; if (b_rise < 0) b_rise = i; end
      if (!rx_busy && prev_busy && b_fall < 0) b_fall = i;
      prev_busy = rx_busy;
    end
    @(negedge clk);
    rx_line = 1'b0;
    rx_en = 1'b1;
  endtask

  initial begin
    #(100000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R9: reset state
    check(rx_data == 7'h00, "R9 data after reset", rx_data, 0);
    check(!rx_valid && !rx_perr, "R9 valid/perr after reset", {rx_valid, rx_perr}, 0);
    check(!rx_busy, "R9 busy after reset", rx_busy, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      frame(VEC[v][6:0], 1'b1, -1, 0, 0, WIN + 20);
      check(b_rise == T_BUSY, "R1 busy rise cycle", b_rise, T_BUSY);
      check(b_fall == T_FALL, "R2 busy fall cycle", b_fall, T_FALL);
      check(v_cyc == T_VAL, "R5 valid cycle", v_cyc, T_VAL);
      check(n_val == 1, "R5 single valid pulse", n_val, 1);
      check(v_data == VEC[v][6:0], "R3 R4 received code", v_data, VEC[v][6:0]);
      check(v_perr == VEC[v][7], "R6 parity fault", v_perr, VEC[v][7]);
      repeat (3) @(negedge clk);
      check(rx_data == VEC[v][6:0] && rx_perr == VEC[v][7], "R9 hold after transfer",
            {rx_perr, rx_data}, VEC[v]);
    end

    // R7: edges inside the window, and the line still high at close
    frame(7'h2A, 1'b1, -1, 130, 220, 320);
    check(n_rise == 1, "R7 window starts once", n_rise, 1);
    check(b_fall == T_FALL, "R7 window not extended", b_fall, T_FALL);
    check(n_val == 1, "R7 no extra transfer", n_val, 1);

    // R8: enable low for the whole frame
    frame(7'h7F, 1'b1, 0, 0, 0, WIN + 20);
    check(b_rise == -1, "R8 no start while disabled", b_rise, -1);
    check(n_val == 0, "R8 no valid while disabled", n_val, 0);
    check(rx_data == 7'h2A, "R8 data untouched", rx_data, 7'h2A);

    // R8: enable drops mid-character
    frame(7'h55, 1'b1, 60, 0, 0, WIN + 20);
    check(b_rise == T_BUSY, "R8 start before drop", b_rise, T_BUSY);
    check(b_fall == T_FALL, "R8 window full length", b_fall, T_FALL);
    check(n_val == 0, "R8 no valid after drop", n_val, 0);

    // R3: level sampled at the bit centres, glitch-free frame after recovery
    frame(7'h01, 1'b1, -1, 0, 0, WIN + 20);
    check(v_data == 7'h01 && v_cyc == T_VAL, "R3 recovery frame", v_data, 7'h01);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule